// File: doc/BRIEF.md
# Lockstep SIMD Lane Array with Activity Stacks

A row of identical 16-bit processing lanes that all obey one broadcast instruction per clock. No lane can branch. Data-dependent work is done by masking instead. Each lane keeps a small stack of activity bits. A compare instruction pushes a new bit that narrows the set of lanes still taking effect, and a pop instruction widens it again. A lane that is switched off still sees every instruction, but its registers and carry stay as they are.

Each lane owns four general registers and a carry flip-flop. Words wider than 16 bits are handled in two instructions: the low halves first, then the high halves with carry or borrow. Lanes sit on a linear chain and can copy a register from the neighbour on either side. A lane at the end of the chain reads zero from the side that has no neighbour. A respond instruction samples the OR of all activity bits onto a global response line. An external controller sequences the program and reads results through a register-select port.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, every register of every lane reads 0, all lanes are active (`active_o` all ones) and `rsp_o` is 0.
- R2: Opcodes 1 to 5 write `dst` with, in turn: A, A&B, A|B, ~(A|B), ~A. A is register `srca` and B is register `srcb` of the same lane. The result is visible on `rd_data_o` on the clock edge that executes the opcode.
- R3: Opcodes 6 (A+B), 8 (A-B), 10 (low 16 bits of A*B), 11 (A shifted left by B[3:0]) and 12 (A shifted right, logically, by B[3:0]) wrap modulo 2^16.
- R4: Opcodes 6 and 8 load the carry flip-flop with the carry out or the borrow. Opcode 7 computes A+B+carry and opcode 9 computes A-B-carry, and both also update the carry. A 32-bit add or subtract therefore takes two instructions: low half first, then high half.
- R5: Opcodes 14 to 19 compare A and B as unsigned values, using in turn >=, >, ==, !=, <=, <. Each pushes (compare result AND current activity) onto the lane's stack, and that bit becomes the new activity. The stack holds 8 entries.
- R6: Opcode 20 pops one entry, which restores the activity the lane had before the matching push. With an empty stack a lane is active.
- R7: A lane whose activity bit is 0 changes neither its registers nor its carry for any opcode.
- R8: Opcode 21 writes `dst` with register `srca` of the lane above it (index+1). Opcode 22 writes it from the lane below it (index-1). The top lane (for 21) and lane 0 (for 22) receive 0.
- R9: Opcode 13 writes the broadcast literal into `dst`.
- R10: Opcode 23 sets `rsp_o`, on its edge, to the OR of the activity bits as they stood before that edge. `rsp_o` holds that value until the next opcode 23.
- R11: Opcode 0 changes no register, activity bit or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 5 | Broadcast opcode |
| dst_i | input | 2 | Destination register index |
| srca_i | input | 2 | First source register index |
| srcb_i | input | 2 | Second source register index |
| lit_i | input | 16 | Broadcast literal |
| rd_sel_i | input | 2 | Register shown on rd_data_o |
| rd_data_o | output | 64 | Selected register of each lane; lane i in bits [16i+15:16i] |
| active_o | output | 4 | Activity bit of each lane |
| rsp_o | output | 1 | Global response line |

## Verification
The assertions assume that the controller never pushes onto a full stack and never pops an empty one. A push on a full stack is dropped and a pop on an empty stack is ignored, so a program that does either loses its pairing between pushes and pops. The bench keeps a model of the stack depth. When a random pick would push at depth 8 it issues a pop instead, and when a pick would pop at depth 0 it issues a push instead. The inactive-hold checks assume that `rd_sel_i` stays put across the instruction being checked. The bench sets the selector together with each instruction and holds it until after the edge.

// File: rtl/simd_pe_pkg.sv
// Shared opcode set and opcode classification for the lockstep lane array.
package simd_pe_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,  OP_PASS = 5'd1,  OP_AND  = 5'd2,  OP_OR   = 5'd3,
        OP_NOR  = 5'd4,  OP_NOT  = 5'd5,  OP_ADD  = 5'd6,  OP_ADDC = 5'd7,
        OP_SUB  = 5'd8,  OP_SUBB = 5'd9,  OP_MUL  = 5'd10, OP_SHL  = 5'd11,
        OP_SHR  = 5'd12, OP_LIT  = 5'd13, OP_PGE  = 5'd14, OP_PGT  = 5'd15,
        OP_PEQ  = 5'd16, OP_PNE  = 5'd17, OP_PLE  = 5'd18, OP_PLT  = 5'd19,
        OP_POP  = 5'd20, OP_NBDN = 5'd21, OP_NBUP = 5'd22, OP_RESP = 5'd23
    } op_e;

    // True for opcodes that write the destination register
    function automatic logic op_writes_reg(op_e op);
        return (op inside {[OP_PASS:OP_LIT], OP_NBDN, OP_NBUP});
    endfunction

    // True for opcodes that update the carry flip-flop
    function automatic logic op_sets_carry(op_e op);
        return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB});
    endfunction

    // True for compare-and-push opcodes
    function automatic logic op_is_push(op_e op);
        return (op inside {[OP_PGE:OP_PLT]});
    endfunction

endpackage

// File: rtl/simd_pe_alu.sv
// Combinational datapath of one lane: arithmetic, logic, shifts, neighbour
// and literal selection, and the six unsigned comparisons.
// Assumes W is a power of two so that B[log2(W)-1:0] covers every shift.
module simd_pe_alu
    import simd_pe_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] lit,
    input  logic [W-1:0] nb_dn,
    input  logic [W-1:0] nb_up,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         carry_out,
    output logic         cmp_true
);
    localparam int SHW = $clog2(W);

    logic [W:0] wide;

    // Select the result, the next carry and the compare outcome for op
    always_comb begin
        res       = a;
        carry_out = carry_in;
        cmp_true  = 1'b0;
        wide      = '0;
        case (op)
            OP_PASS: res = a;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOR:  res = ~(a | b);
            OP_NOT:  res = ~a;
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                res = wide[W-1:0]; carry_out = wide[W];
            end
            OP_ADDC: begin
                wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in};
                res = wide[W-1:0]; carry_out = wide[W];
            end
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                res = wide[W-1:0]; carry_out = wide[W];
            end
            OP_SUBB: begin
                wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, carry_in};
                res = wide[W-1:0]; carry_out = wide[W];
            end
            OP_MUL:  res = a * b;
            OP_SHL:  res = a << b[SHW-1:0];
            OP_SHR:  res = a >> b[SHW-1:0];
            OP_LIT:  res = lit;
            OP_NBDN: res = nb_dn;
            OP_NBUP: res = nb_up;
            OP_PGE:  cmp_true = (a >= b);
            OP_PGT:  cmp_true = (a >  b);
            OP_PEQ:  cmp_true = (a == b);
            OP_PNE:  cmp_true = (a != b);
            OP_PLE:  cmp_true = (a <= b);
            OP_PLT:  cmp_true = (a <  b);
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_ctx_stack.sv
// Per-lane activity stack. Each pushed bit already includes the activity
// at push time, so the top entry alone gives the current activity.
// Assumes the controller never pushes when full nor pops when empty;
// such requests are dropped.
module simd_ctx_stack #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    output logic active
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] bits;
    logic [DW-1:0]    depth;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    new_idx;

    assign top_idx = IW'(depth - 1'b1);
    assign new_idx = IW'(depth);

    // Activity is the top entry, or true when nothing is pushed
    assign active = (depth == '0) ? 1'b1 : bits[top_idx];

    // Push writes above the top and deepens; pop only shrinks the depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits  <= '0;
            depth <= '0;
        end else if (push && depth < DW'(DEPTH)) begin
            bits[new_idx] <= push_bit;
            depth         <= depth + 1'b1;
        end else if (pop && depth != '0) begin
            depth <= depth - 1'b1;
        end
    end
endmodule

// File: rtl/simd_pe_lane.sv
// One processing lane: register file, carry flip-flop, datapath and
// activity stack. Writes of registers and carry are gated by activity;
// the stack itself follows every instruction so depths stay in lockstep.
module simd_pe_lane
    import simd_pe_pkg::*;
#(
    parameter int W     = 16,
    parameter int NREG  = 4,
    parameter int DEPTH = 8,
    localparam int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [RW-1:0] dst,
    input  logic [RW-1:0] sa,
    input  logic [RW-1:0] sb,
    input  logic [W-1:0]  lit,
    input  logic [W-1:0]  nb_dn,
    input  logic [W-1:0]  nb_up,
    input  logic [RW-1:0] rd_sel,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  rd_data,
    output logic          active
);
    logic [W-1:0] regs [NREG];
    logic         carry;
    logic [W-1:0] res;
    logic         carry_nx;
    logic         cmp_true;

    assign a_out   = regs[sa];
    assign rd_data = regs[rd_sel];

    simd_pe_alu #(.W(W)) u_alu (
        .op(op), .a(regs[sa]), .b(regs[sb]), .lit(lit),
        .nb_dn(nb_dn), .nb_up(nb_up), .carry_in(carry),
        .res(res), .carry_out(carry_nx), .cmp_true(cmp_true)
    );

    simd_ctx_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(op_is_push(op)), .push_bit(cmp_true & active),
        .pop(op == OP_POP), .active(active)
    );

    // Register file and carry update, masked by activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            carry <= 1'b0;
        end else if (active) begin
            if (op_writes_reg(op)) regs[dst] <= res;
            if (op_sets_carry(op)) carry <= carry_nx;
        end
    end
endmodule

// File: rtl/simd_pe_array.sv
// Top: NUM_PE lanes on a linear chain sharing one broadcast instruction,
// plus the registered global response line. Lanes at the chain ends see
// zero from the absent neighbour.
module simd_pe_array
    import simd_pe_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int W      = 16,
    parameter int NREG   = 4,
    parameter int DEPTH  = 8,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          op_i,
    input  logic [RW-1:0]       dst_i,
    input  logic [RW-1:0]       srca_i,
    input  logic [RW-1:0]       srcb_i,
    input  logic [W-1:0]        lit_i,
    input  logic [RW-1:0]       rd_sel_i,
    output logic [NUM_PE*W-1:0] rd_data_o,
    output logic [NUM_PE-1:0]   active_o,
    output logic                rsp_o
);
    op_e          op;
    logic [W-1:0] a_vec [NUM_PE];

    assign op = op_e'(op_i);

    for (genvar g = 0; g < NUM_PE; g++) begin : g_lane
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        if (g == NUM_PE - 1) begin : g_top
            assign from_above = '0;
        end else begin : g_mid_a
            assign from_above = a_vec[g+1];
        end
        if (g == 0) begin : g_bot
            assign from_below = '0;
        end else begin : g_mid_b
            assign from_below = a_vec[g-1];
        end

        simd_pe_lane #(.W(W), .NREG(NREG), .DEPTH(DEPTH)) u_lane (
            .clk(clk), .rst_n(rst_n), .op(op),
            .dst(dst_i), .sa(srca_i), .sb(srcb_i), .lit(lit_i),
            .nb_dn(from_above), .nb_up(from_below), .rd_sel(rd_sel_i),
            .a_out(a_vec[g]), .rd_data(rd_data_o[g*W +: W]),
            .active(active_o[g])
        );
    end

    // Response line samples the OR of activity on each respond opcode
    always_ff @(posedge clk) begin
        if (!rst_n)              rsp_o <= 1'b0;
        else if (op == OP_RESP)  rsp_o <= |active_o;
    end
endmodule

// File: rtl/simd_pe_array_chk.sv
// Property checker for the lane array, attached by bind. It relies only on
// the top-level ports and assumes rd_sel_i is steady across a checked edge
// where noted.
module simd_pe_array_chk
    import simd_pe_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int W      = 16,
    parameter int RW     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4:0]          op_i,
    input logic [RW-1:0]       dst_i,
    input logic [RW-1:0]       rd_sel_i,
    input logic [NUM_PE*W-1:0] rd_data_o,
    input logic [NUM_PE-1:0]   active_o,
    input logic                rsp_o
);
    op_e  op;
    logic wr_op;

    assign op    = op_e'(op_i);
    assign wr_op = op_writes_reg(op);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (active_o == '1 && !rsp_o));

    // R5
    push_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_push(op) |=> ((active_o & ~$past(active_o)) == '0));

    // R6
    pop_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |=> (($past(active_o) & ~active_o) == '0));

    // R10
    respond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESP) |=> (rsp_o == |$past(active_o)));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_RESP) |=> $stable(rsp_o));

    // R11
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP) |=> ($stable(active_o) &&
            (rd_sel_i != $past(rd_sel_i) || $stable(rd_data_o))));

    for (genvar g = 0; g < NUM_PE; g++) begin : g_lane_chk
        // R7
        inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_op && !active_o[g] && rd_sel_i == dst_i) |=>
            (rd_sel_i != $past(rd_sel_i) ||
             rd_data_o[g*W +: W] == $past(rd_data_o[g*W +: W])));
    end
endmodule

bind simd_pe_array simd_pe_array_chk #(.NUM_PE(NUM_PE), .W(W), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .active_o(active_o),
    .rsp_o(rsp_o)
);

// File: tb/simd_pe_array_bench.sv
// Bench: directed cases followed by a long pseudo-random instruction sweep,
// checked against an arithmetic model of the requirements.
module simd_pe_array_bench;
    import simd_pe_pkg::*;

    localparam int NP = 4;
    localparam int W  = 16;
    localparam int NR = 4;
    localparam int SD = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        op_i = '0;
    logic [1:0]        dst_i = '0, srca_i = '0, srcb_i = '0, rd_sel_i = '0;
    logic [W-1:0]      lit_i = '0;
    logic [NP*W-1:0]   rd_data_o;
    logic [NP-1:0]     active_o;
    logic              rsp_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [W-1:0] m_reg [NP][NR];
    logic         m_carry [NP];
    logic         m_stk [NP][SD];
    int           m_depth = 0;
    logic         m_rsp = 1'b0;
    logic [31:0]  lfsr = 32'h1d2c3b4a;

    simd_pe_array u_simd_pe_array (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i),
        .srca_i(srca_i), .srcb_i(srcb_i), .lit_i(lit_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .active_o(active_o), .rsp_o(rsp_o)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic m_active(int p);
        return (m_depth == 0) ? 1'b1 : m_stk[p][m_depth-1];
    endfunction

    function automatic logic [NP-1:0] m_mask();
        logic [NP-1:0] m;
        for (int p = 0; p < NP; p++) m[p] = m_active(p);
        return m;
    endfunction

    function automatic string tag_of(op_e op);
        case (op)
            OP_PASS, OP_AND, OP_OR, OP_NOR, OP_NOT:  return "R2";
            OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR:  return "R3";
            OP_ADDC, OP_SUBB:                        return "R4";
            OP_PGE, OP_PGT, OP_PEQ, OP_PNE, OP_PLE, OP_PLT: return "R5";
            OP_POP:                                  return "R6";
            OP_NBDN, OP_NBUP:                        return "R8";
            OP_LIT:                                  return "R9";
            OP_RESP:                                 return "R10";
            default:                                 return "R11";
        endcase
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Drive one instruction, update the model, check after the edge
    task automatic issue(op_e op, int d, int a, int b, logic [W-1:0] lit);
        logic [W-1:0]  av [NP];
        logic [W-1:0]  bv [NP];
        logic [NP-1:0] act;
        logic [W:0]    wide;
        logic [W-1:0]  res;
        logic          cy, cmp, wr, cw;
        @(negedge clk);
        op_i = op; dst_i = 2'(d); srca_i = 2'(a); srcb_i = 2'(b);
        lit_i = lit; rd_sel_i = 2'(d);
        act = m_mask();
        for (int p = 0; p < NP; p++) begin
            av[p] = m_reg[p][a];
            bv[p] = m_reg[p][b];
        end
        for (int p = 0; p < NP; p++) begin
            res = '0; cy = m_carry[p]; cmp = 1'b0; wr = 1'b1; cw = 1'b0;
            case (op)
                OP_PASS: res = av[p];
                OP_AND:  res = av[p] & bv[p];
                OP_OR:   res = av[p] | bv[p];
                OP_NOR:  res = ~(av[p] | bv[p]);
                OP_NOT:  res = ~av[p];
                OP_ADD:  begin wide = 17'(av[p]) + 17'(bv[p]); cw = 1; end
                OP_ADDC: begin wide = 17'(av[p]) + 17'(bv[p]) + 17'(m_carry[p]); cw = 1; end
                OP_SUB:  begin wide = 17'(av[p]) - 17'(bv[p]); cw = 1; end
                OP_SUBB: begin wide = 17'(av[p]) - 17'(bv[p]) - 17'(m_carry[p]); cw = 1; end
                OP_MUL:  res = 16'((32'(av[p]) * 32'(bv[p])) % 65536);
                OP_SHL:  res = av[p] << (bv[p] % 16);
                OP_SHR:  res = av[p] >> (bv[p] % 16);
                OP_LIT:  res = lit;
                OP_NBDN: res = (p == NP-1) ? '0 : av[p+1];
                OP_NBUP: res = (p == 0) ? '0 : av[p-1];
                OP_PGE:  begin cmp = av[p] >= bv[p]; wr = 0; end
                OP_PGT:  begin cmp = av[p] >  bv[p]; wr = 0; end
                OP_PEQ:  begin cmp = av[p] == bv[p]; wr = 0; end
                OP_PNE:  begin cmp = av[p] != bv[p]; wr = 0; end
                OP_PLE:  begin cmp = av[p] <= bv[p]; wr = 0; end
                OP_PLT:  begin cmp = av[p] <  bv[p]; wr = 0; end
                default: wr = 0;
            endcase
            if (cw) begin res = wide[W-1:0]; cy = wide[W]; end
            if (act[p] && wr) m_reg[p][d] = res;
            if (act[p] && cw) m_carry[p] = cy;
            if (op_is_push(op)) m_stk[p][m_depth] = cmp & act[p];
        end
        if (op_is_push(op)) m_depth++;
        if (op == OP_POP) m_depth--;
        if (op == OP_RESP) m_rsp = |act;
        @(posedge clk); #1;
        for (int p = 0; p < NP; p++)
            check((op_writes_reg(op) && !act[p]) ? "R7" : tag_of(op),
                  32'(rd_data_o[p*W +: W]), 32'(m_reg[p][d]));
        check((op == OP_POP) ? "R6" : "R5", 32'(active_o), 32'(m_mask()));
        check("R10", 32'(rsp_o), 32'(m_rsp));
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_carry[p] = 1'b0;
            for (int r = 0; r < NR; r++) m_reg[p][r] = '0;
            for (int s = 0; s < SD; s++) m_stk[p][s] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset contents, activity and response
        for (int r = 0; r < NR; r++) begin
            rd_sel_i = 2'(r); #1;
            check("R1", 32'(rd_data_o), 32'(0));
        end
        check("R1", 32'(active_o), 32'hf);
        check("R1", 32'(rsp_o), 32'(0));

        // R8: distinct lane data from the chain, zero at the ends
        issue(OP_LIT, 0, 0, 0, 16'd5);
        issue(OP_NBDN, 1, 0, 0, 16'd0);
        check("R8", 32'(rd_data_o[3*W +: W]), 32'(0));
        issue(OP_NBUP, 2, 1, 0, 16'd0);
        check("R8", 32'(rd_data_o[0 +: W]), 32'(0));
        check("R8", 32'(rd_data_o[2*W +: W]), 32'(5));

        // R5/R6: lanes holding zero in r1 drop out, pop restores
        issue(OP_LIT, 3, 0, 0, 16'd0);
        issue(OP_PNE, 0, 1, 3, 16'd0);
        check("R5", 32'(active_o), 32'h7);
        issue(OP_LIT, 1, 0, 0, 16'h00aa);
        check("R7", 32'(rd_data_o[3*W +: W]), 32'(0));
        issue(OP_POP, 0, 0, 0, 16'd0);
        check("R6", 32'(active_o), 32'hf);

        // R10: no lane active gives a low response, pop brings it back
        issue(OP_PGT, 0, 0, 0, 16'd0);
        issue(OP_RESP, 0, 0, 0, 16'd0);
        check("R10", 32'(rsp_o), 32'(0));
        issue(OP_POP, 0, 0, 0, 16'd0);
        issue(OP_RESP, 0, 0, 0, 16'd0);
        check("R10", 32'(rsp_o), 32'(1));

        // R4: 32-bit add 0x1234FFFF + 0x00000001 = 0x12350000
        issue(OP_LIT, 0, 0, 0, 16'hffff);
        issue(OP_LIT, 1, 0, 0, 16'h0001);
        issue(OP_LIT, 2, 0, 0, 16'h1234);
        issue(OP_LIT, 3, 0, 0, 16'h0000);
        issue(OP_ADD, 0, 0, 1, 16'd0);
        check("R4", 32'(rd_data_o[W +: W]), 32'h0000);
        issue(OP_ADDC, 2, 2, 3, 16'd0);
        check("R4", 32'(rd_data_o[W +: W]), 32'h1235);
        // R4: 32-bit subtract 0x00010000 - 0x00000001 = 0x0000FFFF
        issue(OP_LIT, 0, 0, 0, 16'h0000);
        issue(OP_LIT, 2, 0, 0, 16'h0001);
        issue(OP_SUB, 0, 0, 1, 16'd0);
        check("R4", 32'(rd_data_o[2*W +: W]), 32'hffff);
        issue(OP_SUBB, 2, 2, 3, 16'd0);
        check("R4", 32'(rd_data_o[2*W +: W]), 32'h0000);

        // R2, R3, R9, R11 and mixtures: pseudo-random sweep
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            op_e  op;
            logic [W-1:0] lit;
            r  = rnd();
            op = op_e'(5'(r % 24));
            if (op_is_push(op) && m_depth == SD) op = OP_POP;
            else if (op == OP_POP && m_depth == 0) op = OP_PGE;
            case (r[31:30])
                2'd0:    lit = 16'h0000;
                2'd1:    lit = 16'hffff;
                default: lit = 16'(rnd());
            endcase
            issue(op, int'(r[9:8]), int'(r[11:10]), int'(r[13:12]), lit);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule